// File: doc/BRIEF.md
# Hypervisor-Aware Interrupt CSR File

This block holds the interrupt enable, pending and delegation state of a hart that may support guest virtualization. It serves every interrupt-related CSR through a single access port. The port carries an address, write data, a write mask and a strobe, and returns read data in the same cycle. The state has three parts: the machine enable register, the machine delegation register, and a set of software-owned pending bits. Each architectural view (machine, supervisor and hypervisor) shows a filtered slice of that state and can change only its own slice.

Thirteen local interrupt lines come in from timers, software-interrupt sources and external controllers. The OR of those lines and the software-owned bits forms the pending vector. The supervisor guest external interrupt (bit 12) is owned by hardware. It follows its input line, and no CSR write can set or clear it. A build parameter says whether the hypervisor extension is present. That parameter decides which addresses are legal, which delegation bits are hard-wired to 1, and whether the guest-external enable bit can hold a 1. Trap selection and priority are left to downstream logic, which reads the three state vectors directly.

Top module: `irq_csr_file`

## Requirements
- R1: During and after reset, the enable vector is 0 and the software pending bits are 0. The delegation vector reads bits 2, 6, 10 and 12 as 1 (0x1444) when the hypervisor extension is present, and reads 0 otherwise.
- R2: Legal addresses are 0x303 (delegation), 0x304 (enable), 0x344 (machine pending), 0x144 (supervisor pending), 0x604 (hypervisor enable), 0x644 (hypervisor pending) and 0x645 (virtual pending). Without the hypervisor extension, 0x604, 0x644 and 0x645 are illegal. A strobed access to an illegal address raises `csr_illegal_o`, reads 0 and changes no state.
- R3: Delegation stores only bits 1, 5, 9 (supervisor set) and 2, 6, 10 (virtual-supervisor set). With the hypervisor extension, bits 2, 6, 10 and 12 always read 1, whatever is written.
- R4: The enable register accepts bits 1, 3, 5, 7, 9, 11, 2, 6, 10 and 12. Without the hypervisor extension, bit 12 always reads 0.
- R5: Every access is a read-modify-write. Each bit that is both writable and set in the mask takes the write-data bit. Every other bit keeps its value. Read data is the value before the write.
- R6: Address 0x144 reads pending AND delegation AND 0x222. A write there can change only bit 1, and only while delegation bit 1 is set.
- R7: Address 0x645 reads pending AND 0x444 and writes the software pending bits 2, 6 and 10.
- R8: Address 0x644 reads pending AND 0x1444 and writes only software pending bit 2. Pending bit 12 always equals input line 12, and writes through 0x344 or 0x644 cannot change it.
- R9: Address 0x604 reads the enable register AND 0x1444 and changes only bits 2, 6, 10 and 12 of it.
- R10: Address 0x344 reads the full pending vector. Writes there reach software pending bits 1, 5 and 9, and also 2, 6 and 10 when the hypervisor extension is present.
- R11: Pending bits 0, 4 and 8 and all read-data bits above 12 read 0, even when the matching input lines are high.
- R12: The outputs `irq_pend_o`, `irq_en_o` and `irq_deleg_o` show the current pending, enable and delegation vectors. A write becomes visible on them one clock edge after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| csr_en_i | input | 1 | Access strobe |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | XLEN | Write data |
| csr_wmask_i | input | XLEN | Per-bit write mask |
| csr_rdata_o | output | XLEN | Pre-write read data of the addressed view |
| csr_illegal_o | output | 1 | Strobed access to an unsupported address |
| irq_lines_i | input | 13 | Local interrupt input lines |
| irq_pend_o | output | 13 | Pending vector |
| irq_en_o | output | 13 | Enable vector |
| irq_deleg_o | output | 13 | Delegation vector |

## Verification
The bench builds two instances side by side with XLEN of 32 and drives them with the same stimulus. One instance has the hypervisor extension present and the other has it absent. This exposes both sides of every parameter-dependent rule at once. The rules covered are the hard-wired delegation bits, the suppressed guest-external enable, and the hypervisor addresses turning illegal. Random masks and line patterns run through a bench model for each instance. Directed steps cover the delegation-gated supervisor write, writes aimed at the hardware-owned bit 12, and partial-mask updates.

// File: rtl/irq_csr_pkg.sv
`timescale 1ns/1ps
package irq_csr_pkg;

  localparam int unsigned NLOC = 13;
  typedef logic [NLOC-1:0] ivec_t;

  // Bit positions (trap logic decodes these)
  localparam int unsigned P_SSI  = 1;
  localparam int unsigned P_VSSI = 2;
  localparam int unsigned P_MSI  = 3;
  localparam int unsigned P_STI  = 5;
  localparam int unsigned P_VSTI = 6;
  localparam int unsigned P_MTI  = 7;
  localparam int unsigned P_SEI  = 9;
  localparam int unsigned P_VSEI = 10;
  localparam int unsigned P_MEI  = 11;
  localparam int unsigned P_SGEI = 12;

  localparam ivec_t GRP_S  = ivec_t'((1 << P_SSI)  | (1 << P_STI)  | (1 << P_SEI));
  localparam ivec_t GRP_VS = ivec_t'((1 << P_VSSI) | (1 << P_VSTI) | (1 << P_VSEI));
  localparam ivec_t GRP_M  = ivec_t'((1 << P_MSI)  | (1 << P_MTI)  | (1 << P_MEI));
  localparam ivec_t ONE_SGEI = ivec_t'(1 << P_SGEI);
  localparam ivec_t ONE_VSSI = ivec_t'(1 << P_VSSI);
  localparam ivec_t ONE_SSI  = ivec_t'(1 << P_SSI);
  localparam ivec_t GRP_HS  = GRP_VS | ONE_SGEI;
  localparam ivec_t GRP_DEF = GRP_M | GRP_S | GRP_HS;

  localparam logic [11:0] A_MDELEG = 12'h303;
  localparam logic [11:0] A_MEN    = 12'h304;
  localparam logic [11:0] A_MPEND  = 12'h344;
  localparam logic [11:0] A_SPEND  = 12'h144;
  localparam logic [11:0] A_HEN    = 12'h604;
  localparam logic [11:0] A_HPEND  = 12'h644;
  localparam logic [11:0] A_VPEND  = 12'h645;

  typedef enum logic [2:0] {
    VW_NONE, VW_MDELEG, VW_MEN, VW_MPEND, VW_SPEND, VW_HEN, VW_HPEND, VW_VPEND
  } view_e;

  // Writable masks that depend on the hypervisor parameter
  function automatic ivec_t en_writable(input bit hyp);
    return hyp ? GRP_DEF : (GRP_DEF & ~ONE_SGEI);
  endfunction

  function automatic ivec_t swp_writable(input bit hyp);
    return hyp ? (GRP_S | GRP_VS) : GRP_S;
  endfunction

  function automatic ivec_t deleg_forced(input bit hyp);
    return hyp ? GRP_HS : '0;
  endfunction

endpackage

// File: rtl/irq_csr_decode.sv
`timescale 1ns/1ps
module irq_csr_decode
  import irq_csr_pkg::*;
#(
  parameter bit HAS_HYP = 1'b1
) (
  input  logic [11:0] addr_i,
  output view_e       view_o
);

  view_e base_view;

  always_comb begin
    unique case (addr_i)
      A_MDELEG: base_view = VW_MDELEG;
      A_MEN:    base_view = VW_MEN;
      A_MPEND:  base_view = VW_MPEND;
      A_SPEND:  base_view = VW_SPEND;
      A_HEN:    base_view = VW_HEN;
      A_HPEND:  base_view = VW_HPEND;
      A_VPEND:  base_view = VW_VPEND;
      default:  base_view = VW_NONE;
    endcase
  end

  generate
    if (HAS_HYP) begin : g_hyp
      assign view_o = base_view;
    end else begin : g_nohyp
      always_comb begin
        if (base_view == VW_HEN || base_view == VW_HPEND || base_view == VW_VPEND)
          view_o = VW_NONE;
        else
          view_o = base_view;
      end
    end
  endgenerate

endmodule

// File: rtl/irq_csr_view.sv
`timescale 1ns/1ps
module irq_csr_view
  import irq_csr_pkg::*;
#(
  parameter bit HAS_HYP = 1'b1
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  view_e view_i,
  input  ivec_t en_vec_i,
  input  ivec_t deleg_i,
  input  ivec_t pend_i,
  output ivec_t rdata_o,
  output logic  illegal_o,
  output ivec_t sel_en_o,
  output ivec_t sel_deleg_o,
  output ivec_t sel_swp_o
);

  localparam ivec_t EN_WR  = en_writable(HAS_HYP);
  localparam ivec_t SWP_WR = swp_writable(HAS_HYP);
  localparam ivec_t DG_WR  = GRP_S | GRP_VS;

  ivec_t sel_en_raw, sel_dg_raw, sel_sp_raw;
  logic  legal;

  always_comb begin
    rdata_o    = '0;
    sel_en_raw = '0;
    sel_dg_raw = '0;
    sel_sp_raw = '0;
    unique case (view_i)
      VW_MDELEG: begin
        rdata_o    = deleg_i;
        sel_dg_raw = DG_WR;
      end
      VW_MEN: begin
        rdata_o    = en_vec_i;
        sel_en_raw = EN_WR;
      end
      VW_MPEND: begin
        rdata_o    = pend_i;
        sel_sp_raw = SWP_WR;
      end
      VW_SPEND: begin
        rdata_o    = pend_i & deleg_i & GRP_S;
        sel_sp_raw = deleg_i[P_SSI] ? ONE_SSI : '0;
      end
      VW_HEN: begin
        rdata_o    = en_vec_i & GRP_HS;
        sel_en_raw = EN_WR & GRP_HS;
      end
      VW_HPEND: begin
        rdata_o    = pend_i & GRP_HS;
        sel_sp_raw = ONE_VSSI;
      end
      VW_VPEND: begin
        rdata_o    = pend_i & GRP_VS;
        sel_sp_raw = GRP_VS;
      end
      default: begin
        rdata_o = '0;
      end
    endcase
  end

  assign legal       = (view_i != VW_NONE);
  assign illegal_o   = en_i & ~legal;
  assign sel_en_o    = (en_i & legal) ? sel_en_raw : '0;
  assign sel_deleg_o = (en_i & legal) ? sel_dg_raw : '0;
  assign sel_swp_o   = (en_i & legal) ? sel_sp_raw : '0;

  // R6: the supervisor pending view never exposes bits outside deleg & S set
  a_r6_spend_subset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (view_i == VW_SPEND) |-> ((rdata_o & ~(deleg_i & GRP_S)) == '0));

  // R2: an illegal access selects no storage for update
  a_r2_illegal_no_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (sel_en_o == '0 && sel_deleg_o == '0 && sel_swp_o == '0));

  // R6: while bit 1 is not delegated the supervisor view writes nothing
  a_r6_spend_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (view_i == VW_SPEND && !deleg_i[P_SSI]) |-> (sel_swp_o == '0));

endmodule

// File: rtl/irq_csr_state.sv
`timescale 1ns/1ps
module irq_csr_state
  import irq_csr_pkg::*;
#(
  parameter bit HAS_HYP = 1'b1
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  ivec_t wdata_i,
  input  ivec_t wmask_i,
  input  ivec_t sel_en_i,
  input  ivec_t sel_deleg_i,
  input  ivec_t sel_swp_i,
  input  ivec_t lines_i,
  output ivec_t en_vec_o,
  output ivec_t deleg_o,
  output ivec_t pend_o
);

  localparam ivec_t DG_FORCE = deleg_forced(HAS_HYP);
  localparam ivec_t DG_KEEP  = (GRP_S | GRP_VS) & ~DG_FORCE;
  localparam ivec_t EN_KEEP  = en_writable(HAS_HYP);
  localparam ivec_t SP_KEEP  = swp_writable(HAS_HYP);

  wire ivec_t dg_w;
  wire ivec_t en_w;
  wire ivec_t sp_w;

  generate
    for (genvar i = 0; i < int'(NLOC); i++) begin : g_bit
      // delegation bit: forced, stored or absent
      if (DG_FORCE[i]) begin : g_dg_one
        assign dg_w[i] = 1'b1;
      end else if (DG_KEEP[i]) begin : g_dg_ff
        logic q, d;
        always_comb d = (sel_deleg_i[i] & wmask_i[i]) ? wdata_i[i] : q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) q <= 1'b0;
          else         q <= d;
        end
        assign dg_w[i] = q;
      end else begin : g_dg_zero
        assign dg_w[i] = 1'b0;
      end

      // enable bit
      if (EN_KEEP[i]) begin : g_en_ff
        logic q, d;
        always_comb d = (sel_en_i[i] & wmask_i[i]) ? wdata_i[i] : q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) q <= 1'b0;
          else         q <= d;
        end
        assign en_w[i] = q;
      end else begin : g_en_zero
        assign en_w[i] = 1'b0;
      end

      // software-owned pending bit
      if (SP_KEEP[i]) begin : g_sp_ff
        logic q, d;
        always_comb d = (sel_swp_i[i] & wmask_i[i]) ? wdata_i[i] : q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) q <= 1'b0;
          else         q <= d;
        end
        assign sp_w[i] = q;
      end else begin : g_sp_zero
        assign sp_w[i] = 1'b0;
      end
    end
  endgenerate

  assign en_vec_o = en_w;
  assign deleg_o  = dg_w;
  assign pend_o   = (sp_w | lines_i) & GRP_DEF;

  logic unused_in;
  assign unused_in = ^{sel_en_i, sel_deleg_i, sel_swp_i, wdata_i, wmask_i};

  // R8: guest external pending is owned by hardware
  a_r8_sgei_claimed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o[P_SGEI] == lines_i[P_SGEI]);

  generate
    if (HAS_HYP) begin : g_chk_hyp
      // R3: hypervisor-level delegation bits are hard-wired
      a_r3_deleg_forced: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (deleg_o & GRP_HS) == GRP_HS);
    end else begin : g_chk_nohyp
      // R4: no guest external enable without the extension
      a_r4_sgei_enable_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_vec_o[P_SGEI]);
    end
  endgenerate

endmodule

// File: rtl/irq_csr_file.sv
`timescale 1ns/1ps
module irq_csr_file
  import irq_csr_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter bit          HAS_HYP = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            csr_en_i,
  input  logic [11:0]     csr_addr_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  input  logic [XLEN-1:0] csr_wmask_i,
  output logic [XLEN-1:0] csr_rdata_o,
  output logic            csr_illegal_o,
  input  logic [12:0]     irq_lines_i,
  output logic [12:0]     irq_pend_o,
  output logic [12:0]     irq_en_o,
  output logic [12:0]     irq_deleg_o
);

  localparam int unsigned PAD = XLEN - NLOC;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q, rst_sync_d;
  logic       rst_core_n;

  always_comb rst_sync_d = {rst_sync_q[0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= rst_sync_d;
  end

  assign rst_core_n = rst_sync_q[1];

  view_e view;
  ivec_t rd_vec, sel_en, sel_dg, sel_sp;
  ivec_t en_vec, dg_vec, pd_vec;
  ivec_t wd_lo, wm_lo;

  assign wd_lo = csr_wdata_i[NLOC-1:0];
  assign wm_lo = csr_wmask_i[NLOC-1:0];

  logic unused_hi;
  assign unused_hi = ^{csr_wdata_i[XLEN-1:NLOC], csr_wmask_i[XLEN-1:NLOC]};

  irq_csr_decode #(.HAS_HYP(HAS_HYP)) u_decode (
    .addr_i (csr_addr_i),
    .view_o (view)
  );

  irq_csr_view #(.HAS_HYP(HAS_HYP)) u_view (
    .clk_i       (clk_i),
    .rst_ni      (rst_core_n),
    .en_i        (csr_en_i),
    .view_i      (view),
    .en_vec_i    (en_vec),
    .deleg_i     (dg_vec),
    .pend_i      (pd_vec),
    .rdata_o     (rd_vec),
    .illegal_o   (csr_illegal_o),
    .sel_en_o    (sel_en),
    .sel_deleg_o (sel_dg),
    .sel_swp_o   (sel_sp)
  );

  irq_csr_state #(.HAS_HYP(HAS_HYP)) u_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_core_n),
    .wdata_i     (wd_lo),
    .wmask_i     (wm_lo),
    .sel_en_i    (sel_en),
    .sel_deleg_i (sel_dg),
    .sel_swp_i   (sel_sp),
    .lines_i     (irq_lines_i),
    .en_vec_o    (en_vec),
    .deleg_o     (dg_vec),
    .pend_o      (pd_vec)
  );

  assign csr_rdata_o = {{PAD{1'b0}}, rd_vec};
  assign irq_pend_o  = pd_vec;
  assign irq_en_o    = en_vec;
  assign irq_deleg_o = dg_vec;

  // R2: an illegal access leaves enable and delegation untouched
  a_r2_illegal_keeps_state: assert property (@(posedge clk_i) disable iff (!rst_core_n)
    csr_illegal_o |=> ($stable(irq_en_o) && $stable(irq_deleg_o)));

  // R5: an access with an empty mask changes no register
  a_r5_empty_mask_keeps: assert property (@(posedge clk_i) disable iff (!rst_core_n)
    (csr_en_i && csr_wmask_i == '0) |=> ($stable(irq_en_o) && $stable(irq_deleg_o)));

  // R11: bits above the local range always read zero
  a_r11_rdata_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_core_n)
    csr_rdata_o[XLEN-1:NLOC] == '0);

endmodule

// File: tb/tb_irq_csr_file.sv
`timescale 1ns/1ps
module tb_irq_csr_file;

  localparam int XLEN = 32;

  logic            clk, rst_n, en;
  logic [11:0]     addr;
  logic [XLEN-1:0] wdata, wmask;
  logic [12:0]     lines;
  logic [XLEN-1:0] rd_h, rd_n;
  logic            il_h, il_n;
  logic [12:0]     pd_h, en_h, dg_h, pd_n, en_n, dg_n;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  irq_csr_file #(.XLEN(XLEN), .HAS_HYP(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .csr_en_i(en), .csr_addr_i(addr),
    .csr_wdata_i(wdata), .csr_wmask_i(wmask), .csr_rdata_o(rd_h),
    .csr_illegal_o(il_h), .irq_lines_i(lines), .irq_pend_o(pd_h),
    .irq_en_o(en_h), .irq_deleg_o(dg_h));

  irq_csr_file #(.XLEN(XLEN), .HAS_HYP(1'b0)) dut_nohyp (
    .clk_i(clk), .rst_ni(rst_n), .csr_en_i(en), .csr_addr_i(addr),
    .csr_wdata_i(wdata), .csr_wmask_i(wmask), .csr_rdata_o(rd_n),
    .csr_illegal_o(il_n), .irq_lines_i(lines), .irq_pend_o(pd_n),
    .irq_en_o(en_n), .irq_deleg_o(dg_n));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // bench model, index 0 = with extension, 1 = without
  logic [12:0] m_en [2];
  logic [12:0] m_dg [2];
  logic [12:0] m_sp [2];

  function automatic bit hyp(int k); return k == 0; endfunction

  function automatic logic [12:0] dg_eff(int k);
    return (m_dg[k] & 13'h0666) | (hyp(k) ? 13'h1444 : 13'h0000);
  endfunction

  function automatic logic [12:0] pd_eff(int k);
    return (m_sp[k] | lines) & 13'h1EEE;
  endfunction

  function automatic bit legal(int k, logic [11:0] a);
    case (a)
      12'h303, 12'h304, 12'h344, 12'h144: return 1'b1;
      12'h604, 12'h644, 12'h645:          return hyp(k);
      default:                            return 1'b0;
    endcase
  endfunction

  function automatic logic [12:0] rd_exp(int k, logic [11:0] a);
    if (!legal(k, a)) return 13'h0;
    case (a)
      12'h303: return dg_eff(k);
      12'h304: return m_en[k];
      12'h344: return pd_eff(k);
      12'h144: return pd_eff(k) & dg_eff(k) & 13'h0222;
      12'h604: return m_en[k] & 13'h1444;
      12'h644: return pd_eff(k) & 13'h1444;
      12'h645: return pd_eff(k) & 13'h0444;
      default: return 13'h0;
    endcase
  endfunction

  function automatic logic [12:0] upd(logic [12:0] o, logic [12:0] d,
                                      logic [12:0] m, logic [12:0] w);
    return (o & ~(m & w)) | (d & m & w);
  endfunction

  function automatic string tag_of(logic [11:0] a);
    case (a)
      12'h303: return "R3";
      12'h304: return "R4";
      12'h344: return "R10";
      12'h144: return "R6";
      12'h604: return "R9";
      12'h644: return "R8";
      12'h645: return "R7";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_outputs(string tag);
    chk(tag, "pend hyp",   {19'd0, pd_h}, {19'd0, pd_eff(0)});
    chk(tag, "en hyp",     {19'd0, en_h}, {19'd0, m_en[0]});
    chk(tag, "deleg hyp",  {19'd0, dg_h}, {19'd0, dg_eff(0)});
    chk(tag, "pend nohyp", {19'd0, pd_n}, {19'd0, pd_eff(1)});
    chk(tag, "en nohyp",   {19'd0, en_n}, {19'd0, m_en[1]});
    chk(tag, "deleg nohyp",{19'd0, dg_n}, {19'd0, dg_eff(1)});
  endtask

  task automatic access(logic [11:0] a, logic [31:0] d, logic [31:0] m,
                        logic [12:0] ln, bit e, string tg);
    string t;
    logic [12:0] ne [2];
    logic [12:0] nd [2];
    logic [12:0] ns [2];
    logic [12:0] d13, m13;
    t = (tg == "") ? tag_of(a) : tg;
    @(negedge clk);
    en = e; addr = a; wdata = d; wmask = m; lines = ln;
    #2;
    d13 = d[12:0]; m13 = m[12:0];
    chk(t, "rdata hyp",   rd_h, {19'd0, rd_exp(0, a)});
    chk(t, "rdata nohyp", rd_n, {19'd0, rd_exp(1, a)});
    chk("R2", "illegal hyp",   {31'd0, il_h}, {31'd0, e & ~legal(0, a)});
    chk("R2", "illegal nohyp", {31'd0, il_n}, {31'd0, e & ~legal(1, a)});
    for (int k = 0; k < 2; k++) begin
      ne[k] = m_en[k]; nd[k] = m_dg[k]; ns[k] = m_sp[k];
      if (e && legal(k, a)) begin
        case (a)
          12'h303: nd[k] = upd(m_dg[k], d13, m13, 13'h0666);
          12'h304: ne[k] = upd(m_en[k], d13, m13, hyp(k) ? 13'h1EEE : 13'h0EEE);
          12'h604: ne[k] = upd(m_en[k], d13, m13, 13'h1444);
          12'h344: ns[k] = upd(m_sp[k], d13, m13, hyp(k) ? 13'h0666 : 13'h0222);
          12'h144: ns[k] = upd(m_sp[k], d13, m13, dg_eff(k)[1] ? 13'h0002 : 13'h0000);
          12'h644: ns[k] = upd(m_sp[k], d13, m13, 13'h0004);
          12'h645: ns[k] = upd(m_sp[k], d13, m13, 13'h0444);
          default: ;
        endcase
      end
    end
    @(posedge clk);
    #1;
    for (int k = 0; k < 2; k++) begin
      m_en[k] = ne[k]; m_dg[k] = nd[k]; m_sp[k] = ns[k];
    end
    check_outputs((tg == "") ? "R12" : tg);
  endtask

  function automatic logic [11:0] pick_addr();
    case ($urandom_range(0, 8))
      0: return 12'h303;
      1: return 12'h304;
      2: return 12'h344;
      3: return 12'h144;
      4: return 12'h604;
      5: return 12'h644;
      6: return 12'h645;
      7: return 12'h305;
      default: return 12'($urandom_range(0, 4095));
    endcase
  endfunction

  initial begin
    #(20 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20211026));
    for (int k = 0; k < 2; k++) begin
      m_en[k] = '0; m_dg[k] = '0; m_sp[k] = '0;
    end
    rst_n = 1'b0; en = 1'b0; addr = '0; wdata = '0; wmask = '0; lines = '0;
    repeat (3) @(posedge clk);
    #1;
    check_outputs("R1");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check_outputs("R1");

    // R3: delegation write of all ones
    access(12'h303, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 13'h0, 1'b1, "R3");
    access(12'h303, 32'h0, 32'h0, 13'h0, 1'b1, "R3");
    // R6: clear delegation then try supervisor write
    access(12'h303, 32'h0, 32'hFFFF_FFFF, 13'h0, 1'b1, "R6");
    access(12'h144, 32'h2, 32'h2, 13'h0, 1'b1, "R6");
    access(12'h344, 32'h0, 32'h0, 13'h0, 1'b1, "R6");
    access(12'h303, 32'h2, 32'h2, 13'h0, 1'b1, "R6");
    access(12'h144, 32'h2, 32'h2, 13'h0, 1'b1, "R6");
    access(12'h144, 32'h0, 32'h0, 13'h0, 1'b1, "R6");
    // R8: writes aimed at guest external pending
    access(12'h644, 32'h1FFF, 32'h1FFF, 13'h0, 1'b1, "R8");
    access(12'h344, 32'h1000, 32'h1000, 13'h0, 1'b1, "R8");
    access(12'h644, 32'h0, 32'h0, 13'h1000, 1'b1, "R8");
    access(12'h644, 32'h0, 32'h1000, 13'h1000, 1'b1, "R8");
    // R7: virtual pending
    access(12'h645, 32'h0444, 32'h0444, 13'h0, 1'b1, "R7");
    access(12'h645, 32'h0, 32'h0, 13'h0, 1'b1, "R7");
    // R4: enable all ones
    access(12'h304, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 13'h0, 1'b1, "R4");
    // R9: hypervisor enable clear
    access(12'h604, 32'h0, 32'hFFFF_FFFF, 13'h0, 1'b1, "R9");
    access(12'h304, 32'h0, 32'h0, 13'h0, 1'b1, "R9");
    // R5: partial mask
    access(12'h304, 32'h0, 32'h00F0, 13'h0, 1'b1, "R5");
    access(12'h304, 32'h0, 32'h0, 13'h0, 1'b1, "R5");
    // R2: illegal address and a strobe-less access
    access(12'h305, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 13'h0, 1'b1, "R2");
    access(12'h304, 32'h0, 32'hFFFF_FFFF, 13'h0, 1'b0, "R2");
    // R11: all lines high
    access(12'h344, 32'h0, 32'h0, 13'h1FFF, 1'b1, "R11");
    // R10: machine pending write
    access(12'h344, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 13'h0, 1'b1, "R10");
    access(12'h344, 32'h0, 32'h0, 13'h0, 1'b1, "R10");

    for (int n = 0; n < 600; n++) begin
      logic [31:0] rd, rm;
      rd = $urandom;
      rm = ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF : $urandom;
      access(pick_addr(), rd, rm, 13'($urandom), ($urandom_range(0, 7) != 0), "");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule